// File: doc/BRIEF.md
# Interrupt Distributor Register Block

This block sits between the interrupt lines of a small multiprocessor's peripherals and the CPUs. For every interrupt ID it holds an enable bit, a pending bit, an active bit, an 8-bit priority, a CPU target set and a trigger mode. Software reaches this state through a word-addressed synchronous register bus. Each bus access carries the number of the CPU that issues it. For each CPU the block picks the best interrupt that is ready for that CPU and presents it as a registered valid/ID pair.

IDs 0 to 31 are private: every CPU has its own enable, pending and active bits for them. The bus CPU number selects which copy an access reaches. IDs from 32 upward are shared and are driven by the `irq_in` lines, one line per ID starting at ID 32. Software can mark a private ID pending on any set of CPUs with a single write to the software-raise register. A CPU-side interface, outside this block, reports each accepted interrupt through `cpu_ack` and each finished interrupt through `cpu_eoi`.

Top module: `irq_distributor`

## Requirements
- R1: Bit 0 of the control word at 0x000 is the global forward enable. It resets to 0 and reads back. While it is 0, `cpu_irq_valid` stays 0 for every CPU.
- R2: The read-only word at 0x004 returns NUM_IDS/32-1 in bits [4:0] and zero in the other bits (1 with the defaults).
- R3: The enable banks are at 0x100 (set) and 0x180 (clear). ID n lives in word 0x100+(n/32)*4 (or the clear-bank equivalent) at bit n%32. Writing a 1 sets or clears that enable and writing a 0 changes nothing. A read of either bank returns the current enables.
- R4: The pending banks are at 0x200 (set) and 0x280 (clear) and use the same bit layout as R3; a read of either returns the pending bits. The active bits read at 0x300 in the same layout, and writes there are ignored.
- R5: Priorities are at 0x400 + (n/4)*4, one byte per ID, with byte lane n%4 at bits [8*(n%4)+7 : 8*(n%4)]. They reset to 0 and can be written and read back.
- R6: Targets are at 0x800 + (n/4)*4, in the same byte layout as R5, and bit k of a byte selects CPU k. For IDs below 32 the byte reads as 1 shifted left by the accessing CPU number, and writes to it are ignored.
- R7: The trigger mode is at 0xC00 + (n/16)*4, with 2 bits per ID. Bit 2*(n%16)+1 is 1 for edge and 0 for level, and the mode is stored only for IDs of 32 and above. For private IDs these bits read 0.
- R8: For IDs 0 to 31 the enable, pending and active bits are banked per CPU. `bus_cpu` chooses the bank that a read or write reaches.
- R9: A write to 0xF00 with CPU list bits [23:16] and ID bits [4:0] sets that private ID pending in the bank of every listed CPU.
- R10: For each CPU the forwarded interrupt is the enabled, pending, non-active ID that targets that CPU and has the lowest priority value; on a tie the lower ID wins. `cpu_irq_valid`/`cpu_irq_id` reflect the state one clock after it changes.
- R11: A level-mode shared ID that is not active has its pending bit follow its input, one clock late. An edge-mode shared ID becomes pending on a rising input and stays pending until it is cleared.
- R12: `cpu_ack[c]` while `cpu_irq_valid[c]` is 1 marks the forwarded ID active and clears its pending bit. `cpu_eoi[c]` with `cpu_eoi_id` clears the active bit (the bank of CPU c for private IDs).
- R13: Read data arrives the clock after `bus_rd` and is zero when there was no read. Reads of unmapped or misaligned addresses, or of IDs at or above NUM_IDS, return 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | NUM_IDS-32 | Shared interrupt lines, bit j drives ID 32+j |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_cpu | input | CPU_W | Number of the CPU issuing the access |
| bus_rdata | output | 32 | Registered read data |
| cpu_irq_valid | output | NUM_CPUS | Per-CPU interrupt request |
| cpu_irq_id | output | NUM_CPUS*ID_W | Per-CPU forwarded ID, CPU c at bits [c*ID_W +: ID_W] |
| cpu_ack | input | NUM_CPUS | CPU c accepts its forwarded interrupt |
| cpu_eoi | input | NUM_CPUS | CPU c finishes an interrupt |
| cpu_eoi_id | input | NUM_CPUS*ID_W | ID finished by CPU c |

## Verification
Some properties are checked on every clock by assertions. These cover read data that only arrives after a read and is zero otherwise, the type word, zero returns from unmapped offsets, and the private target bytes matching the accessing CPU. They also check that no request is raised while the shadowed global enable is off, and that an acknowledged ID is not offered again to the same CPU one cycle later. The bench scenarios show what needs a history of bus traffic. That covers bank separation between CPUs, software raises to several CPUs, and priority ties settled by ID. It also covers a level input being held off while active and followed again after end-of-interrupt, and an edge pulse latched until software clears it.

// File: rtl/idist_pkg.sv
// Package: shared constants, region type and the address decoder for the
// interrupt distributor. Assumes a 12-bit byte address space.
package idist_pkg;

    localparam int ADDR_W = 12;
    localparam int PRIO_W = 8;
    localparam int PRIV_N = 32;

    typedef enum logic [3:0] {
        RG_NONE, RG_CTRL, RG_TYPE, RG_EN_SET, RG_EN_CLR, RG_PD_SET,
        RG_PD_CLR, RG_ACT, RG_PRIO, RG_TGT, RG_CFG, RG_SGI
    } region_e;

    // Map a byte address to its register region; misaligned maps to none.
    function automatic region_e idist_decode(input logic [ADDR_W-1:0] a);
        if (a[1:0] != 2'b00)            return RG_NONE;
        if (a[11:2] == 10'h000)         return RG_CTRL;
        if (a[11:2] == 10'h001)         return RG_TYPE;
        if (a[11:2] == 10'h3C0)         return RG_SGI;
        case (a[11:7])
            5'h02: return RG_EN_SET;
            5'h03: return RG_EN_CLR;
            5'h04: return RG_PD_SET;
            5'h05: return RG_PD_CLR;
            5'h06: return RG_ACT;
            default: ;
        endcase
        if (a[11:10] == 2'b01)          return RG_PRIO;
        if (a[11:10] == 2'b10)          return RG_TGT;
        if (a[11:8] == 4'hC)            return RG_CFG;
        return RG_NONE;
    endfunction

endpackage

// File: rtl/idist_select.sv
// Winner scan for one CPU: among candidate IDs picks the lowest priority
// value, lower ID on ties. Purely combinational; assumes cand is already
// masked by enable, pending, active and target.
module idist_select #(
    parameter int NUM_IDS = 64,
    parameter int ID_W    = 6
) (
    input  logic [NUM_IDS-1:0]   cand,
    input  logic [NUM_IDS*8-1:0] prio_flat,
    output logic                 found,
    output logic [ID_W-1:0]      win_id
);
    logic [7:0] best_p;

    // Linear scan, strict compare keeps the earlier (lower) ID on a tie.
    always_comb begin
        found  = 1'b0;
        best_p = 8'hFF;
        win_id = '0;
        for (int i = 0; i < NUM_IDS; i++) begin
            if (cand[i] && (!found || prio_flat[8*i +: 8] < best_p)) begin
                found  = 1'b1;
                best_p = prio_flat[8*i +: 8];
                win_id = ID_W'(i);
            end
        end
    end
endmodule

// File: rtl/idist_readback.sv
// Read multiplexer: forms the 32-bit word for a decoded region from the
// state as seen by the accessing CPU. Assumes views are already banked.
module idist_readback
    import idist_pkg::*;
#(
    parameter int NUM_IDS  = 64,
    parameter int NUM_CPUS = 2,
    parameter int CPU_W    = 1
) (
    input  region_e                        rg,
    input  logic [7:0]                     widx,
    input  logic [CPU_W-1:0]               cpu,
    input  logic                           ctrl_en,
    input  logic [NUM_IDS-1:0]             en_v,
    input  logic [NUM_IDS-1:0]             pd_v,
    input  logic [NUM_IDS-1:0]             ac_v,
    input  logic [NUM_IDS*8-1:0]           prio_flat,
    input  logic [(NUM_IDS-32)*NUM_CPUS-1:0] tgt_flat,
    input  logic [NUM_IDS-33:0]            edg,
    output logic [31:0]                    word
);
    localparam int NUM_WORDS = NUM_IDS / 32;
    localparam int SH_N      = NUM_IDS - 32;

    // Select one 32-bit slice of a per-ID bit vector; out of range gives 0.
    function automatic logic [31:0] pick(input logic [NUM_IDS-1:0] v,
                                         input logic [4:0] w);
        logic [31:0] r;
        r = '0;
        for (int k = 0; k < NUM_WORDS; k++)
            if (w == 5'(k)) r = v[32*k +: 32];
        return r;
    endfunction

    // Build the read word for the current region.
    always_comb begin
        word = '0;
        case (rg)
            RG_CTRL:             word[0]   = ctrl_en;
            RG_TYPE:             word[4:0] = 5'(NUM_WORDS - 1);
            RG_EN_SET, RG_EN_CLR: word     = pick(en_v, widx[4:0]);
            RG_PD_SET, RG_PD_CLR: word     = pick(pd_v, widx[4:0]);
            RG_ACT:              word      = pick(ac_v, widx[4:0]);
            RG_PRIO: begin
                for (int i = 0; i < NUM_IDS; i++)
                    if (widx == 8'(i/4)) word[8*(i%4) +: 8] = prio_flat[8*i +: 8];
            end
            RG_TGT: begin
                for (int i = 0; i < 32; i++)
                    if (widx == 8'(i/4)) word[8*(i%4) +: 8] = 8'(1) << cpu;
                for (int j = 0; j < SH_N; j++)
                    if (widx == 8'((j+32)/4))
                        word[8*((j+32)%4) +: NUM_CPUS] = tgt_flat[j*NUM_CPUS +: NUM_CPUS];
            end
            RG_CFG: begin
                for (int j = 0; j < SH_N; j++)
                    if (widx[5:0] == 6'((j+32)/16)) word[2*((j+32)%16)+1] = edg[j];
            end
            default: word = '0;
        endcase
    end
endmodule

// File: rtl/irq_distributor.sv
// Interrupt distributor: per-ID enable/pending/active/priority/target/mode
// state behind a word register bus, banked private IDs 0..31 per CPU, and a
// registered per-CPU winner. Assumes NUM_IDS is a multiple of 32, at least 64
// and at most 1020 rounded to words; NUM_CPUS at most 8.
module irq_distributor
    import idist_pkg::*;
#(
    parameter int NUM_IDS  = 64,
    parameter int NUM_CPUS = 2,
    localparam int ID_W    = $clog2(NUM_IDS),
    localparam int CPU_W   = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
    localparam int SH_N    = NUM_IDS - 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [SH_N-1:0]            irq_in,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [31:0]                bus_wdata,
    input  logic                       bus_wr,
    input  logic                       bus_rd,
    input  logic [CPU_W-1:0]           bus_cpu,
    output logic [31:0]                bus_rdata,
    output logic [NUM_CPUS-1:0]        cpu_irq_valid,
    output logic [NUM_CPUS*ID_W-1:0]   cpu_irq_id,
    input  logic [NUM_CPUS-1:0]        cpu_ack,
    input  logic [NUM_CPUS-1:0]        cpu_eoi,
    input  logic [NUM_CPUS*ID_W-1:0]   cpu_eoi_id
);
    region_e rg;
    logic    ctrl_en;
    logic [NUM_CPUS-1:0][31:0]          en_pv, pd_pv, ac_pv;
    logic [NUM_CPUS-1:0][31:0]          ack_pv, eoi_pv, sgi_set;
    logic [SH_N-1:0]                    en_sh, pd_sh, ac_sh, edg_sh, in_q;
    logic [SH_N-1:0]                    ack_sh, eoi_sh, pend_base;
    logic [SH_N-1:0][NUM_CPUS-1:0]      tgt_sh;
    logic [NUM_IDS-1:0][PRIO_W-1:0]     prio;
    logic [NUM_IDS-1:0]                 bus_bits, es, ec, ps, pc;
    logic [NUM_IDS-1:0]                 en_v, pd_v, ac_v;
    logic [NUM_CPUS-1:0]                is_bank, win_found;
    logic [NUM_CPUS-1:0][ID_W-1:0]      win_id, out_id, eoi_id_a;
    logic [31:0]                        rd_word;

    assign rg          = idist_decode(bus_addr);
    assign cpu_irq_id  = out_id;
    assign eoi_id_a    = cpu_eoi_id;

    // Per-ID write-one mask for the bit banks (word = addr[6:2]).
    always_comb begin
        for (int i = 0; i < NUM_IDS; i++)
            bus_bits[i] = (bus_addr[6:2] == 5'(i/32)) && bus_wdata[i%32];
        es = (bus_wr && rg == RG_EN_SET) ? bus_bits : '0;
        ec = (bus_wr && rg == RG_EN_CLR) ? bus_bits : '0;
        ps = (bus_wr && rg == RG_PD_SET) ? bus_bits : '0;
        pc = (bus_wr && rg == RG_PD_CLR) ? bus_bits : '0;
    end

    // Bank select, acknowledge/end masks and software raise per CPU.
    always_comb begin
        ack_sh = '0;
        eoi_sh = '0;
        for (int c = 0; c < NUM_CPUS; c++) begin
            is_bank[c] = (bus_cpu == CPU_W'(c));
            ack_pv[c]  = '0;
            eoi_pv[c]  = '0;
            sgi_set[c] = '0;
            if (bus_wr && rg == RG_SGI && bus_wdata[16+c])
                sgi_set[c][bus_wdata[4:0]] = 1'b1;
            for (int i = 0; i < NUM_IDS; i++) begin
                if (cpu_ack[c] && cpu_irq_valid[c] && out_id[c] == ID_W'(i)) begin
                    if (i < 32) ack_pv[c][i%32] = 1'b1;
                    else        ack_sh[(i-32)%SH_N] = 1'b1;
                end
                if (cpu_eoi[c] && eoi_id_a[c] == ID_W'(i)) begin
                    if (i < 32) eoi_pv[c][i%32] = 1'b1;
                    else        eoi_sh[(i-32)%SH_N] = 1'b1;
                end
            end
        end
        pend_base = (pd_sh | ps[NUM_IDS-1:32] | (edg_sh & irq_in & ~in_q))
                    & ~pc[NUM_IDS-1:32] & ~ack_sh;
    end

    // Bit-bank state: enables, pending (level follows input), active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_en <= 1'b0;
            en_pv   <= '0;
            pd_pv   <= '0;
            ac_pv   <= '0;
            en_sh   <= '0;
            pd_sh   <= '0;
            ac_sh   <= '0;
            in_q    <= '0;
        end else begin
            if (bus_wr && rg == RG_CTRL) ctrl_en <= bus_wdata[0];
            in_q <= irq_in;
            for (int c = 0; c < NUM_CPUS; c++) begin
                if (is_bank[c]) en_pv[c] <= (en_pv[c] | es[31:0]) & ~ec[31:0];
                pd_pv[c] <= (pd_pv[c] | (is_bank[c] ? ps[31:0] : 32'h0) | sgi_set[c])
                            & ~(is_bank[c] ? pc[31:0] : 32'h0) & ~ack_pv[c];
                ac_pv[c] <= (ac_pv[c] | ack_pv[c]) & ~eoi_pv[c];
            end
            en_sh <= (en_sh | es[NUM_IDS-1:32]) & ~ec[NUM_IDS-1:32];
            ac_sh <= (ac_sh | ack_sh) & ~eoi_sh;
            for (int j = 0; j < SH_N; j++)
                pd_sh[j] <= (!edg_sh[j] && !ac_sh[j] && !ack_sh[j]) ? irq_in[j]
                                                                    : pend_base[j];
        end
    end

    // Byte and mode state: priorities, shared targets, trigger modes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prio   <= '0;
            tgt_sh <= '0;
            edg_sh <= '0;
        end else if (bus_wr) begin
            for (int i = 0; i < NUM_IDS; i++)
                if (rg == RG_PRIO && bus_addr[9:2] == 8'(i/4))
                    prio[i] <= bus_wdata[8*(i%4) +: 8];
            for (int j = 0; j < SH_N; j++) begin
                if (rg == RG_TGT && bus_addr[9:2] == 8'((j+32)/4))
                    tgt_sh[j] <= bus_wdata[8*((j+32)%4) +: NUM_CPUS];
                if (rg == RG_CFG && bus_addr[7:2] == 6'((j+32)/16))
                    edg_sh[j] <= bus_wdata[2*((j+32)%16)+1];
            end
        end
    end

    // One winner scan per CPU over that CPU's banked view.
    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
        logic [SH_N-1:0]    tgt_col;
        logic [NUM_IDS-1:0] cand;
        // Pull this CPU's target column out of the shared targets.
        always_comb begin
            for (int j = 0; j < SH_N; j++) tgt_col[j] = tgt_sh[j][c];
        end
        assign cand = {en_sh & pd_sh & ~ac_sh & tgt_col,
                       en_pv[c] & pd_pv[c] & ~ac_pv[c]};
        idist_select #(.NUM_IDS(NUM_IDS), .ID_W(ID_W)) u_sel (
            .cand      (cand),
            .prio_flat (prio),
            .found     (win_found[c]),
            .win_id    (win_id[c])
        );
    end

    // Register the per-CPU request, gated by the global enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_irq_valid <= '0;
            out_id        <= '0;
        end else begin
            cpu_irq_valid <= {NUM_CPUS{ctrl_en}} & win_found;
            out_id        <= win_id;
        end
    end

    // Banked view of the bit state for the accessing CPU.
    always_comb begin
        en_v = '0;
        pd_v = '0;
        ac_v = '0;
        for (int c = 0; c < NUM_CPUS; c++)
            if (is_bank[c]) begin
                en_v = {en_sh, en_pv[c]};
                pd_v = {pd_sh, pd_pv[c]};
                ac_v = {ac_sh, ac_pv[c]};
            end
    end

    idist_readback #(.NUM_IDS(NUM_IDS), .NUM_CPUS(NUM_CPUS), .CPU_W(CPU_W)) u_rb (
        .rg        (rg),
        .widx      (bus_addr[9:2]),
        .cpu       (bus_cpu),
        .ctrl_en   (ctrl_en),
        .en_v      (en_v),
        .pd_v      (pd_v),
        .ac_v      (ac_v),
        .prio_flat (prio),
        .tgt_flat  (tgt_sh),
        .edg       (edg_sh),
        .word      (rd_word)
    );

    // Registered read data, zero on cycles without a read.
    always_ff @(posedge clk) begin
        if (!rst_n) bus_rdata <= '0;
        else        bus_rdata <= bus_rd ? rd_word : 32'h0;
    end
endmodule

// File: rtl/idist_checker.sv
// Checker: port-level properties of the distributor, bound to every instance.
// Keeps its own shadow of the global enable from observed bus writes.
module idist_checker #(
    parameter int NUM_IDS  = 64,
    parameter int NUM_CPUS = 2,
    localparam int ID_W    = $clog2(NUM_IDS),
    localparam int CPU_W   = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [11:0]              bus_addr,
    input logic                     wdata_bit0,
    input logic                     bus_wr,
    input logic                     bus_rd,
    input logic [CPU_W-1:0]         bus_cpu,
    input logic [31:0]              bus_rdata,
    input logic [NUM_CPUS-1:0]      cpu_irq_valid,
    input logic [NUM_CPUS*ID_W-1:0] cpu_irq_id,
    input logic [NUM_CPUS-1:0]      cpu_ack,
    input logic [NUM_CPUS-1:0]      cpu_eoi
);
    logic shadow_en;
    logic unmapped;

    // Track the global enable as software writes it.
    always_ff @(posedge clk) begin
        if (!rst_n) shadow_en <= 1'b0;
        else if (bus_wr && bus_addr == 12'h000) shadow_en <= wdata_bit0;
    end

    assign unmapped = (bus_addr[1:0] == 2'b00) &&
                      ((bus_addr[11:7] == 5'h00 && bus_addr[6:2] >= 5'd2) ||
                       (bus_addr[11:7] == 5'h07));

    assert_gate_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !shadow_en |=> (cpu_irq_valid == '0));

    assert_type_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 12'h004) |=> (bus_rdata == 32'(NUM_IDS/32 - 1)));

    assert_private_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr[11:10] == 2'b10 && bus_addr[9:5] == 5'd0 && bus_addr[1:0] == 2'b00)
        |=> (bus_rdata == {4{8'(1) << $past(bus_cpu)}}));

    assert_unmapped_zero_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && unmapped) |=> (bus_rdata == 32'h0));

    assert_idle_read_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == 32'h0));

    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_ack
        assert_ack_withdrawn_R12: assert property (@(posedge clk) disable iff (!rst_n)
            (cpu_ack[c] && cpu_irq_valid[c] && cpu_eoi == '0) |=> ##1
            !(cpu_irq_valid[c] &&
              cpu_irq_id[c*ID_W +: ID_W] == $past(cpu_irq_id[c*ID_W +: ID_W], 2)));
    end
endmodule

bind irq_distributor idist_checker #(.NUM_IDS(NUM_IDS), .NUM_CPUS(NUM_CPUS)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_addr      (bus_addr),
    .wdata_bit0    (bus_wdata[0]),
    .bus_wr        (bus_wr),
    .bus_rd        (bus_rd),
    .bus_cpu       (bus_cpu),
    .bus_rdata     (bus_rdata),
    .cpu_irq_valid (cpu_irq_valid),
    .cpu_irq_id    (cpu_irq_id),
    .cpu_ack       (cpu_ack),
    .cpu_eoi       (cpu_eoi)
);

// File: tb/irq_distributor_test.sv
// Scoreboard bench: read tasks queue expected words, a monitor compares them
// when the registered read data appears; request outputs checked directly.
module irq_distributor_test;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_IDS    = 64;
    localparam int NUM_CPUS   = 2;
    localparam int ID_W       = 6;
    localparam int SH_N       = NUM_IDS - 32;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic [SH_N-1:0]          irq_in = '0;
    logic [11:0]              bus_addr = '0;
    logic [31:0]              bus_wdata = '0;
    logic                     bus_wr = 1'b0;
    logic                     bus_rd = 1'b0;
    logic [0:0]               bus_cpu = '0;
    logic [31:0]              bus_rdata;
    logic [NUM_CPUS-1:0]      cpu_irq_valid;
    logic [NUM_CPUS*ID_W-1:0] cpu_irq_id;
    logic [NUM_CPUS-1:0]      cpu_ack = '0;
    logic [NUM_CPUS-1:0]      cpu_eoi = '0;
    logic [NUM_CPUS*ID_W-1:0] cpu_eoi_id = '0;

    irq_distributor #(.NUM_IDS(NUM_IDS), .NUM_CPUS(NUM_CPUS)) uut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_cpu(bus_cpu),
        .bus_rdata(bus_rdata), .cpu_irq_valid(cpu_irq_valid), .cpu_irq_id(cpu_irq_id),
        .cpu_ack(cpu_ack), .cpu_eoi(cpu_eoi), .cpu_eoi_id(cpu_eoi_id)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct { logic [31:0] val; string tag; } exp_t;
    exp_t sb_q[$];
    int   n_run = 0;
    int   n_fail = 0;
    logic rd_due = 1'b0;
    bit   done = 1'b0;

    task automatic check_eq(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: note a read at the edge, compare its data at the next falling edge.
    always @(posedge clk) rd_due <= bus_rd;
    always @(negedge clk) begin
        if (rd_due && sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check_eq(bus_rdata, e.val, e.tag);
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input int cpu);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_cpu = 1'(cpu); bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input int cpu, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a; bus_cpu = 1'(cpu); bus_rd = 1'b1;
        sb_q.push_back('{exp, tag});
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic check_irq(input int c, input logic v, input int id, input string tag);
        check_eq({25'b0, cpu_irq_valid[c], cpu_irq_id[c*ID_W +: ID_W]},
                 {25'b0, v, v ? 6'(id) : cpu_irq_id[c*ID_W +: ID_W]}, tag);
    endtask

    task automatic pulse_ack(input int c);
        @(negedge clk); cpu_ack[c] = 1'b1;
        @(negedge clk); cpu_ack[c] = 1'b0;
    endtask

    task automatic pulse_eoi(input int c, input int id);
        @(negedge clk); cpu_eoi[c] = 1'b1; cpu_eoi_id[c*ID_W +: ID_W] = 6'(id);
        @(negedge clk); cpu_eoi[c] = 1'b0;
    endtask

    task automatic finish_run();
        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state
        check_eq({30'b0, cpu_irq_valid}, 32'h0, "R1 reset no request");
        rd(12'h000, 0, 32'h0, "R1 control resets to 0");
        rd(12'h004, 0, 32'h1, "R2 type word");
        rd(12'h104, 0, 32'h0, "R3 enables reset clear");

        wr(12'h000, 32'h1, 0);
        rd(12'h000, 1, 32'h1, "R1 control reads back");

        // Shared ID 40: priority, target CPU1, enable, level input
        wr(12'h428, 32'h0000_00A0, 0);
        rd(12'h428, 1, 32'h0000_00A0, "R5 priority lane 0");
        wr(12'h828, 32'h0000_0002, 0);
        rd(12'h828, 0, 32'h0000_0002, "R6 shared target byte");
        rd(12'h800, 0, 32'h0101_0101, "R6 private target cpu0");
        wr(12'h800, 32'hFFFF_FFFF, 1);
        rd(12'h800, 1, 32'h0202_0202, "R6 private target cpu1 write ignored");
        wr(12'h104, 32'h0000_0100, 0);
        rd(12'h184, 1, 32'h0000_0100, "R3 clear bank reads enables");
        irq_in[8] = 1'b1;
        settle();
        check_irq(1, 1'b1, 40, "R11 level input forwards to cpu1");
        check_irq(0, 1'b0, 0, "R10 untargeted cpu0 idle");
        rd(12'h204, 0, 32'h0000_0100, "R4 pending reads");

        // Global enable gate
        wr(12'h000, 32'h0, 0);
        settle();
        check_irq(1, 1'b0, 0, "R1 disabled blocks forwarding");
        wr(12'h000, 32'h1, 0);
        settle();
        check_irq(1, 1'b1, 40, "R1 re-enabled forwards");

        // Acknowledge and end of interrupt on a level input
        pulse_ack(1);
        settle();
        check_irq(1, 1'b0, 0, "R12 acked ID withdrawn");
        rd(12'h304, 0, 32'h0000_0100, "R12 active set by ack");
        rd(12'h204, 1, 32'h0, "R11 pending held off while active");
        wr(12'h304, 32'hFFFF_FFFF, 0);
        rd(12'h304, 1, 32'h0000_0100, "R4 active writes ignored");
        pulse_eoi(1, 40);
        settle();
        check_irq(1, 1'b1, 40, "R11 pending follows input after eoi");
        irq_in[8] = 1'b0;
        settle();
        check_irq(1, 1'b0, 0, "R11 input low drops request");
        rd(12'h204, 0, 32'h0, "R11 pending follows low input");

        // Write-one semantics
        wr(12'h104, 32'h0, 0);
        rd(12'h104, 0, 32'h0000_0100, "R3 zero write no effect");
        wr(12'h184, 32'h0000_0100, 1);
        rd(12'h104, 0, 32'h0, "R3 clear bank clears");

        // Banked private IDs and software raise
        wr(12'h100, 32'h0000_0020, 0);
        rd(12'h100, 1, 32'h0, "R8 cpu1 bank unaffected");
        rd(12'h100, 0, 32'h0000_0020, "R8 cpu0 bank set");
        wr(12'h404, 32'h4000_4000, 0);
        wr(12'hF00, 32'h0001_0005, 0);
        settle();
        check_irq(0, 1'b1, 5, "R9 raise to cpu0 forwards");
        check_irq(1, 1'b0, 0, "R9 cpu1 not listed");
        wr(12'hF00, 32'h0003_0007, 1);
        rd(12'h200, 0, 32'h0000_00A0, "R9 cpu0 pending bank");
        rd(12'h200, 1, 32'h0000_0080, "R9 cpu1 pending bank");
        wr(12'h100, 32'h0000_0080, 0);
        settle();
        check_irq(0, 1'b1, 5, "R10 tie goes to lower ID");
        wr(12'h404, 32'h1000_4000, 0);
        settle();
        check_irq(0, 1'b1, 7, "R10 lower priority value wins");

        // Shared level ID 33 to cpu0 and edge ID 34 to cpu1
        wr(12'h820, 32'h0002_0100, 0);
        wr(12'h420, 32'h0000_0800, 0);
        wr(12'hC08, 32'h0000_0020, 0);
        rd(12'hC08, 1, 32'h0000_0020, "R7 mode reads back");
        rd(12'hC00, 0, 32'h0, "R7 private mode reads zero");
        wr(12'h104, 32'h0000_0006, 0);
        irq_in[1] = 1'b1;
        settle();
        check_irq(0, 1'b1, 33, "R10 shared beats private by priority");
        @(negedge clk); irq_in[2] = 1'b1;
        @(negedge clk); irq_in[2] = 1'b0;
        settle();
        check_irq(1, 1'b1, 34, "R11 edge pulse latched");
        wr(12'h284, 32'h0000_0004, 1);
        settle();
        check_irq(1, 1'b0, 0, "R4 pending clear removes edge");

        // Unmapped space
        rd(12'h008, 0, 32'h0, "R13 unmapped control space");
        wr(12'h108, 32'hFFFF_FFFF, 0);
        rd(12'h108, 0, 32'h0, "R13 ID beyond count");
        rd(12'hD00, 1, 32'h0, "R13 unmapped high space");
        rd(12'h101, 0, 32'h0, "R13 misaligned read");

        done = 1'b1;
        finish_run();
    end
endmodule